// File: doc/BRIEF.md
# I2C Serial Memory Slave Interface

This block is the slave-side front end of a 512-byte serial memory on an I2C bus. The memory is split into two 256-byte halves. The block oversamples SCL and SDA with the system clock and finds START and STOP conditions. It shifts in a select byte, a byte address and data bytes, and acknowledges them by pulling SDA low through an open-drain output enable. It serves single, random and sequential reads, and the read pointer advances after each byte sent.

Write bytes pass, with their 9-bit addresses, to an internal write engine. The engine gathers one row of bytes. After the STOP that closes the write, it runs a timed programming cycle and copies the gathered bytes into a synchronous RAM. For the whole of that cycle the interface takes no notice of the bus. Two strap inputs set the slave's bus address, so four such slaves can share one bus.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0. The block changes `sda_oe_o` only while the synchronised SCL is low, and `sda_oe_o` = 1 pulls the line low.
- R2: The select byte arrives MSB first. Bits [7:4] must equal the type code 4'b1010 and bits [3:2] must equal `strap_i`. Bit [1] is the block bit and bit [0] is R/W, where 1 means read. On a match the slave drives ACK (line low) during the ninth clock. On a mismatch the line stays high.
- R3: A write select, a byte address and one data byte, closed by STOP, store that byte at {block bit, byte address}. A later random read returns it. The random read is a write select, the address, a repeated START and a read select.
- R4: The block bit selects the half. The same byte address in block 0 and in block 1 holds two independent bytes.
- R5: In a sequential read the master ACKs each byte. The pointer then advances by one and wraps from 9'h1FF to 9'h000.
- R6: A read select with no address phase starts at the byte after the last one transferred. Bit 8 of that address comes from the select's block bit.
- R7: Data bytes in one write transfer go to consecutive offsets within one 8-byte row. The address is bits [8:3] plus a 3-bit offset, and past offset 7 the offset wraps to 0 of the same row. No byte outside that row changes. The bytes are programmed only after the STOP.
- R8: After a STOP that ends a write with data, the slave ignores START and gives no ACK for PROG_CYCLES clocks. After that it acknowledges again.
- R9: After the master NACKs a read byte, the slave releases SDA and does not drive it again until the next START. After a STOP it accepts a new transfer.
- R10: After a mismatched select, the slave acknowledges none of the following bytes and writes none of them into the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| strap_i | input | 2 | Address straps compared with select bits [3:2] |

## Verification
The bench builds the block with PROG_CYCLES at 300 instead of its long default. This keeps the whole programming window short enough that the bench can probe for no-ACK inside it and for an ACK just after it. Every transfer can then be read back within the run. PAGE_BYTES stays at 8 and SYNC_STAGES at 2. The straps are tied to 2'b10, so a select that differs in one strap bit tests the mismatch path. With these values the row wrap at offset 7 and the pointer wrap at 9'h1FF fall inside a handful of directed transfers. A seeded random phase writes rows of varying length at random addresses and checks each byte against a model.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
   localparam int MEM_AW = 9;
   localparam int BYTE_W = 8;
   localparam int BIT_CW = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SEL,
      PH_ADR,
      PH_WDAT,
      PH_ACK,
      PH_RDAT,
      PH_MACK
   } phase_t;
endpackage

// File: rtl/i2c_mem_sync.sv
module i2c_mem_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_c;
   logic [STAGES-1:0] sda_c;
   logic              scl_q;
   logic              sda_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_c[g] <= 1'b1;
            sda_c[g] <= 1'b1;
         end else begin
            scl_c[g] <= (g == 0) ? scl_i : scl_c[(g == 0) ? 0 : g-1];
            sda_c[g] <= (g == 0) ? sda_i : sda_c[(g == 0) ? 0 : g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_c[STAGES-1];
         sda_q <= sda_c[STAGES-1];
      end
   end

   assign scl_s     = scl_c[STAGES-1];
   assign sda_s     = sda_c[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_mem_wreng.sv
module i2c_mem_wreng
   import i2c_mem_pkg::*;
#(
   parameter int PAGE_BYTES  = 8,
   parameter int PROG_CYCLES = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [MEM_AW-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              commit,
   input  logic [MEM_AW-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              busy
);
   localparam int IDX_W  = $clog2(PAGE_BYTES);
   localparam int BASE_W = MEM_AW - IDX_W;
   localparam int CNT_W  = $clog2(PROG_CYCLES + 1);
   localparam int DEPTH  = 1 << MEM_AW;

   logic [BYTE_W-1:0]     mem  [DEPTH];
   logic [BYTE_W-1:0]     pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] pvld;
   logic [BASE_W-1:0]     pbase;
   logic                  have;
   logic [CNT_W-1:0]      cnt;
   logic [IDX_W-1:0]      widx;
   logic [IDX_W-1:0]      pidx;
   logic                  prog_we;

   assign widx    = wr_addr[IDX_W-1:0];
   assign pidx    = cnt[IDX_W-1:0];
   assign prog_we = busy && (cnt < CNT_W'(PAGE_BYTES)) && pvld[pidx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         have  <= 1'b0;
         pvld  <= '0;
         pbase <= '0;
         cnt   <= '0;
      end else if (busy) begin
         if (cnt == CNT_W'(PROG_CYCLES - 1)) begin
            busy <= 1'b0;
            have <= 1'b0;
            pvld <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (commit && have) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (wr_valid) begin
         if (!have) pbase <= wr_addr[MEM_AW-1:IDX_W];
         have       <= 1'b1;
         pvld[widx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_valid && !busy) pbuf[widx] <= wr_data;
      if (prog_we) mem[{pbase, pidx}] <= pbuf[pidx];
      rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/i2c_mem_proto.sv
module i2c_mem_proto
   import i2c_mem_pkg::*;
#(
   parameter logic [3:0] DEV_TYPE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [1:0]        strap,
   input  logic              busy,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [MEM_AW-1:0] rd_addr,
   output logic              sda_oe,
   output logic              wr_valid,
   output logic [MEM_AW-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              commit
);
   phase_t            ph;
   phase_t            ph_after;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] tx;
   logic [BIT_CW-1:0] bcnt;
   logic              blk;
   logic              mack;
   logic [MEM_AW-1:0] addr;
   logic              rx_ph;

   assign rd_addr = addr;
   assign rx_ph   = (ph == PH_SEL) || (ph == PH_ADR) || (ph == PH_WDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         ph_after <= PH_IDLE;
         sh       <= '0;
         tx       <= '0;
         bcnt     <= '0;
         blk      <= 1'b0;
         mack     <= 1'b0;
         addr     <= '0;
         sda_oe   <= 1'b0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         commit   <= 1'b0;
      end else begin
         wr_valid <= 1'b0;
         commit   <= 1'b0;
         if (busy) begin
            ph     <= PH_IDLE;
            sda_oe <= 1'b0;
            bcnt   <= '0;
         end else if (start_det) begin
            ph     <= PH_SEL;
            sda_oe <= 1'b0;
            bcnt   <= '0;
         end else if (stop_det) begin
            ph     <= PH_IDLE;
            sda_oe <= 1'b0;
            commit <= 1'b1;
         end else if (scl_rise) begin
            sh <= {sh[BYTE_W-2:0], sda_s};
            if (rx_ph) bcnt <= bcnt + 1'b1;
            if (ph == PH_MACK) mack <= ~sda_s;
         end else if (scl_fall) begin
            unique case (ph)
               PH_SEL, PH_ADR, PH_WDAT: begin
                  if (bcnt == BIT_CW'(BYTE_W)) begin
                     bcnt <= '0;
                     if (ph == PH_SEL) begin
                        if (sh[7:4] == DEV_TYPE && sh[3:2] == strap) begin
                           sda_oe <= 1'b1;
                           ph     <= PH_ACK;
                           blk    <= sh[1];
                           if (sh[0]) begin
                              ph_after         <= PH_RDAT;
                              addr[MEM_AW-1]   <= sh[1];
                           end else begin
                              ph_after <= PH_ADR;
                           end
                        end else begin
                           ph <= PH_IDLE;
                        end
                     end else if (ph == PH_ADR) begin
                        addr     <= {blk, sh};
                        sda_oe   <= 1'b1;
                        ph       <= PH_ACK;
                        ph_after <= PH_WDAT;
                     end else begin
                        wr_valid <= 1'b1;
                        wr_addr  <= addr;
                        wr_data  <= sh;
                        addr     <= addr + 1'b1;
                        sda_oe   <= 1'b1;
                        ph       <= PH_ACK;
                        ph_after <= PH_WDAT;
                     end
                  end
               end
               PH_ACK: begin
                  if (ph_after == PH_RDAT) begin
                     tx     <= rd_data;
                     sda_oe <= ~rd_data[BYTE_W-1];
                     bcnt   <= BIT_CW'(1);
                     ph     <= PH_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     bcnt   <= '0;
                     ph     <= ph_after;
                  end
               end
               PH_RDAT: begin
                  if (bcnt == BIT_CW'(BYTE_W)) begin
                     sda_oe <= 1'b0;
                     ph     <= PH_MACK;
                     addr   <= addr + 1'b1;
                  end else begin
                     sda_oe <= ~tx[BYTE_W-2];
                     tx     <= {tx[BYTE_W-2:0], 1'b0};
                     bcnt   <= bcnt + 1'b1;
                  end
               end
               PH_MACK: begin
                  if (mack) begin
                     tx     <= rd_data;
                     sda_oe <= ~rd_data[BYTE_W-1];
                     bcnt   <= BIT_CW'(1);
                     ph     <= PH_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     ph     <= PH_IDLE;
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
   import i2c_mem_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         PAGE_BYTES  = 8,
   parameter int         PROG_CYCLES = 500000,
   parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [1:0] strap_i
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two between 2 and 256");
   end
   if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_prog
      $error("PROG_CYCLES must cover one cycle per buffered byte");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              busy;
   logic              commit;
   logic              wr_valid;
   logic [MEM_AW-1:0] wr_addr;
   logic [BYTE_W-1:0] wr_data;
   logic [MEM_AW-1:0] rd_addr;
   logic [BYTE_W-1:0] rd_data;

   i2c_mem_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_mem_proto #(.DEV_TYPE(DEV_TYPE)) proto_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .strap     (strap_i),
      .busy      (busy),
      .rd_data   (rd_data),
      .rd_addr   (rd_addr),
      .sda_oe    (sda_oe_o),
      .wr_valid  (wr_valid),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .commit    (commit)
   );

   i2c_mem_wreng #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) wreng_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .commit   (commit),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .busy     (busy)
   );
endmodule

// File: rtl/i2c_mem_chk.sv
module i2c_mem_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic stop_det,
   input logic sda_oe_o,
   input logic busy,
   input logic wr_valid
);
   assert_oe_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

   assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe_o);

   assert_prog_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det, 2));

   assert_no_wr_in_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !busy);
endmodule

bind i2c_mem_slave i2c_mem_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .stop_det (stop_det),
   .sda_oe_o (sda_oe_o),
   .busy     (busy),
   .wr_valid (wr_valid)
);

// File: tb/i2c_mem_slave_tb_top.sv
module i2c_mem_slave_tb_top;
   localparam int         PROG  = 300;
   localparam int         Q     = 5;
   localparam logic [1:0] STRAP = 2'b10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic       sda_line;
   logic [7:0] model [512];
   logic [7:0] wbuf  [8];
   logic [7:0] rbuf  [8];
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   assign sda_line = sda_m & ~sda_oe;
   always #5 clk = ~clk;

   i2c_mem_slave #(.SYNC_STAGES(2), .PAGE_BYTES(8), .PROG_CYCLES(PROG)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe),
      .strap_i  (STRAP)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] sel(input bit blk, input bit rd, input logic [1:0] st);
      return {4'b1010, st, blk, rd};
   endfunction

   function automatic logic [8:0] row_addr(input logic [8:0] base, input int k);
      logic [2:0] off;
      off = base[2:0] + 3'(k);
      return {base[8:3], off};
   endfunction

   task automatic i2c_start();
      sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
   endtask

   task automatic bit_clk(input bit b, output bit s);
      sda_m = b; wt(Q); scl = 1'b1; wt(Q); s = sda_line; scl = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
      bit_clk(1'b1, s);
      ack = (s == 1'b0);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] d);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         bit_clk(1'b1, s);
         d[i] = s;
      end
      bit_clk(!give_ack, s);
   endtask

   task automatic do_write(input bit blk, input logic [7:0] a, input int n, output bit ok);
      bit k;
      i2c_start();
      send_byte(sel(blk, 1'b0, STRAP), k); ok = k;
      send_byte(a, k); ok &= k;
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], k); ok &= k;
      end
      i2c_stop();
      if (ok) for (int i = 0; i < n; i++) model[row_addr({blk, a}, i)] = wbuf[i];
   endtask

   task automatic do_rd(input bit blk, input logic [7:0] a, input int n, output bit ok);
      bit k;
      i2c_start();
      send_byte(sel(blk, 1'b0, STRAP), k); ok = k;
      send_byte(a, k); ok &= k;
      i2c_start();
      send_byte(sel(blk, 1'b1, STRAP), k); ok &= k;
      for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
      i2c_stop();
   endtask

   task automatic wait_prog();
      wt(PROG + 30);
   endtask

   initial begin
      bit ok, k, s;
      logic [8:0] fa;
      void'($urandom(32'd5150));
      wt(4);
      check(sda_oe == 1'b0, "R1 oe in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      wt(4);
      check(sda_oe == 1'b0 && sda_line == 1'b1, "R1 idle after reset", int'(sda_oe), 0);

      // R2 select matching
      i2c_start(); send_byte({4'b1011, STRAP, 2'b00}, k); i2c_stop();
      check(!k, "R2 wrong type nack", int'(k), 0);
      i2c_start(); send_byte(sel(1'b0, 1'b0, STRAP ^ 2'b01), k); i2c_stop();
      check(!k, "R2 wrong strap nack", int'(k), 0);
      i2c_start(); send_byte(sel(1'b1, 1'b0, STRAP), k); i2c_stop();
      check(k, "R2 match ack", int'(k), 1);

      // R3 byte write then random read
      wbuf[0] = 8'h5A; do_write(1'b0, 8'h10, 1, ok); wait_prog();
      check(ok, "R3 write acked", int'(ok), 1);
      do_rd(1'b0, 8'h10, 1, ok);
      check(ok && rbuf[0] == 8'h5A, "R3 random read", int'(rbuf[0]), 'h5A);

      // R4 block halves and R8 busy window
      wbuf[0] = 8'hA5; do_write(1'b1, 8'h10, 1, ok);
      i2c_start(); send_byte(sel(1'b0, 1'b0, STRAP), k); i2c_stop();
      check(!k, "R8 no ack while programming", int'(k), 0);
      wait_prog();
      i2c_start(); send_byte(sel(1'b0, 1'b0, STRAP), k); i2c_stop();
      check(k, "R8 ack after programming", int'(k), 1);
      do_rd(1'b1, 8'h10, 1, ok);
      check(rbuf[0] == 8'hA5, "R4 block1 byte", int'(rbuf[0]), 'hA5);
      do_rd(1'b0, 8'h10, 1, ok);
      check(rbuf[0] == 8'h5A, "R4 block0 byte kept", int'(rbuf[0]), 'h5A);

      // R7 row rollover
      wbuf[0] = 8'h11; do_write(1'b0, 8'h48, 1, ok); wait_prog();
      for (int i = 0; i < 4; i++) wbuf[i] = 8'hC0 + 8'(i);
      do_write(1'b0, 8'h46, 4, ok); wait_prog();
      do_rd(1'b0, 8'h46, 2, ok);
      check(rbuf[0] == 8'hC0 && rbuf[1] == 8'hC1, "R7 row tail", int'(rbuf[1]), 'hC1);
      do_rd(1'b0, 8'h40, 2, ok);
      check(rbuf[0] == 8'hC2 && rbuf[1] == 8'hC3, "R7 wrapped to row start", int'(rbuf[0]), 'hC2);
      do_rd(1'b0, 8'h48, 1, ok);
      check(rbuf[0] == 8'h11, "R7 next row untouched", int'(rbuf[0]), 'h11);

      // R5 sequential wrap 1FF -> 000
      for (int i = 0; i < 8; i++) wbuf[i] = 8'h30 + 8'(i);
      do_write(1'b1, 8'hF8, 8, ok); wait_prog();
      for (int i = 0; i < 4; i++) wbuf[i] = 8'h90 + 8'(i);
      do_write(1'b0, 8'h00, 4, ok); wait_prog();
      do_rd(1'b1, 8'hFE, 4, ok);
      for (int i = 0; i < 4; i++) begin
         fa = 9'h1FE + 9'(i);
         check(rbuf[i] == model[fa], "R5 sequential wrap", int'(rbuf[i]), int'(model[fa]));
      end

      // R6 current address read, R9 release after NACK
      i2c_start(); send_byte(sel(1'b0, 1'b1, STRAP), k);
      recv_byte(1'b0, rbuf[0]);
      check(k && rbuf[0] == model[9'h002], "R6 current address", int'(rbuf[0]), int'(model[9'h002]));
      check(sda_oe == 1'b0, "R9 released after nack", int'(sda_oe), 0);
      for (int i = 0; i < 3; i++) begin
         bit_clk(1'b1, s);
         check(s == 1'b1, "R9 line stays high", int'(s), 1);
      end
      i2c_stop();
      i2c_start(); send_byte(sel(1'b0, 1'b1, STRAP), k);
      recv_byte(1'b0, rbuf[0]); i2c_stop();
      check(k, "R9 new transfer accepted", int'(k), 1);

      // R10 mismatch ignores rest of transfer
      i2c_start(); send_byte(sel(1'b0, 1'b0, STRAP ^ 2'b01), k);
      check(!k, "R10 select nack", int'(k), 0);
      send_byte(8'h10, k);
      check(!k, "R10 address nack", int'(k), 0);
      send_byte(8'hEE, k);
      check(!k, "R10 data nack", int'(k), 0);
      i2c_stop(); wait_prog();
      do_rd(1'b0, 8'h10, 1, ok);
      check(rbuf[0] == 8'h5A, "R10 array unchanged", int'(rbuf[0]), 'h5A);

      // random rows, R3 and R7
      for (int it = 0; it < 10; it++) begin
         bit rb;
         logic [7:0] ra;
         int rn;
         rb = 1'($urandom % 2);
         ra = 8'($urandom % 256);
         rn = 1 + int'($urandom % 6);
         for (int i = 0; i < rn; i++) wbuf[i] = 8'($urandom);
         do_write(rb, ra, rn, ok); wait_prog();
         check(ok, "R3 random write acked", int'(ok), 1);
         for (int i = 0; i < rn; i++) begin
            fa = row_addr({rb, ra}, i);
            do_rd(fa[8], fa[7:0], 1, ok);
            check(rbuf[0] == model[fa], "R7 random row byte", int'(rbuf[0]), int'(model[fa]));
         end
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule